// File: doc/BRIEF.md
# Charge Pump Ratio Sequencer

This block chooses the multiplication ratio of the charge pump that feeds a bank of LED current sinks. Each channel has a comparator that flags when its sink no longer has enough headroom. The block keeps only the flags of channels that are switched on and ORs them together. When that combined condition stays true for a programmable settling window, the block moves the pump up to the next ratio: 1x, then 1.5x, then 2x. If the condition is still present at 2x, the ratio wraps back to 1x and the climb starts again.

A strobe from the register file drops the ratio back to 1x at any time, and the search then restarts from the bottom. While the device-enable input is low, the block holds an off code. When enable rises again, the block restarts at 1x. The comparator flags come from the analog side, so they pass through a synchronizer whose depth is set by a parameter. The enable input, the channel mask and the strobe are all synchronous to the block clock.

Top module: `pump_ratio_seq`

## Requirements
- R1: One clock edge after `dev_on` rises, `ratio_code` becomes 2'b01 (1x). It stays at 1x for as long as no enabled channel reports dropout.
- R2: A channel whose bit in `ch_mask` is 0 has no effect on the ratio. A dropout flag on any one channel whose mask bit is 1 is enough to start a step.
- R3: A step happens only after the synchronized dropout condition has been true on FILT_TICKS consecutive edges. A flag driven high is first counted SYNC_STAGES+1 edges later, so the code changes SYNC_STAGES+FILT_TICKS edges after the flag rises. A shorter run of dropout clears the count and causes no step.
- R4: Steps go upward one ratio at a time: 2'b01 (1x) to 2'b10 (1.5x) to 2'b11 (2x).
- R5: If dropout persists at 2x, the next expiry moves the code from 2'b11 to 2'b01. The count restarts at every mode change, so each new mode gets a full FILT_TICKS window.
- R6: A one-cycle `to_base` pulse while enabled sets the code to 2'b01 on the next edge and clears the count. A new full window must then elapse before the next step.
- R7: While `dev_on` is low, `ratio_code` is 2'b00 and `ratio_ok` is 0 from the next edge on, whatever the dropout flags and the strobe do. After reset the outputs are 2'b00 and 0.
- R8: If `to_base` is high on the same edge on which the window expires, the strobe wins: the code goes to 2'b01, not to the next ratio.
- R9: `ratio_ok` is 1 exactly when `ratio_code` is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_on | input | 1 | Device enable; low forces the off state |
| drop_flag | input | NUM_CH | Per-channel dropout flags from the comparators, asynchronous |
| ch_mask | input | NUM_CH | Per-channel enable; 1 means the channel is active |
| to_base | input | 1 | One-cycle strobe that forces the ratio back to 1x |
| ratio_code | output | 2 | 00 off, 01 1x, 10 1.5x, 11 2x |
| ratio_ok | output | 1 | High when the ratio code is not off |

## Verification
The collision that matters is a `to_base` strobe arriving on the exact edge where the settling window expires. On that edge the block could either climb a ratio or fall back to 1x. The bench holds a dropout flag steady and times the strobe so that it is sampled on that edge. It then expects a move to 1x in that cycle, and the next step a full window later, in a cycle it computes in advance. A second overlap is a strobe sampled part-way through a window at 1x: there the expected step is pushed back by the cleared count.

// File: rtl/pump_ratio_pkg.sv
package pump_ratio_pkg;

   typedef enum logic [1:0] {
      RATIO_OFF = 2'b00,
      RATIO_X1  = 2'b01,
      RATIO_X15 = 2'b10,
      RATIO_X2  = 2'b11
   } ratio_e;

   // upward step with wrap from the top ratio back to 1x
   function automatic ratio_e ratio_after(input ratio_e cur);
      case (cur)
         RATIO_X1:  ratio_after = RATIO_X15;
         RATIO_X15: ratio_after = RATIO_X2;
         RATIO_X2:  ratio_after = RATIO_X1;
         default:   ratio_after = RATIO_X1;
      endcase
   endfunction

endpackage

// File: rtl/pump_flag_sync.sv
module pump_flag_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_sync = d_async;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d_async;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q_sync = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pump_dropout_gate.sv
module pump_dropout_gate #(
   parameter int W = 6
) (
   input  logic [W-1:0] flags,
   input  logic [W-1:0] mask,
   output logic         any_drop
);

   logic [W-1:0] live;

   generate
      for (genvar c = 0; c < W; c++) begin : g_ch
         assign live[c] = flags[c] & mask[c];
      end
   endgenerate

   assign any_drop = |live;

endmodule

// File: rtl/pump_settle_timer.sv
module pump_settle_timer #(
   parameter int TICKS = 160000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic hit,
   output logic expire
);

   localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt_q;
   logic          at_last;

   assign at_last = (cnt_q == LAST);
   assign expire  = hit & at_last & ~clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clear || !hit)   cnt_q <= '0;
      else if (at_last)         cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/pump_ratio_fsm.sv
module pump_ratio_fsm
   import pump_ratio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dev_on,
   input  logic       to_base,
   input  logic       expire,
   output ratio_e     ratio,
   output logic       valid
);

   ratio_e ratio_q;
   logic   valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= RATIO_OFF;
         valid_q <= 1'b0;
      end else begin
         valid_q <= dev_on;
         if (!dev_on)                  ratio_q <= RATIO_OFF;
         else if (ratio_q == RATIO_OFF) ratio_q <= RATIO_X1;
         else if (to_base)             ratio_q <= RATIO_X1;
         else if (expire)              ratio_q <= ratio_after(ratio_q);
      end
   end

   assign ratio = ratio_q;
   assign valid = valid_q;

endmodule

// File: rtl/pump_ratio_seq.sv
module pump_ratio_seq
   import pump_ratio_pkg::*;
#(
   parameter int NUM_CH      = 6,
   parameter int FILT_TICKS  = 160000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_on,
   input  logic [NUM_CH-1:0] drop_flag,
   input  logic [NUM_CH-1:0] ch_mask,
   input  logic              to_base,
   output logic [1:0]        ratio_code,
   output logic              ratio_ok
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("pump_ratio_seq: NUM_CH must be at least 1");
      end
      if (FILT_TICKS < 2) begin : g_bad_filt
         $error("pump_ratio_seq: FILT_TICKS must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("pump_ratio_seq: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [NUM_CH-1:0] flag_s;
   logic              hit_gated;
   logic              win_clear;
   logic              win_expire;
   ratio_e            ratio_now;

   pump_flag_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (drop_flag),
      .q_sync  (flag_s)
   );

   pump_dropout_gate #(.W(NUM_CH)) u_gate (
      .flags    (flag_s),
      .mask     (ch_mask),
      .any_drop (hit_gated)
   );

   assign win_clear = ~dev_on | (ratio_now == RATIO_OFF) | to_base;

   pump_settle_timer #(.TICKS(FILT_TICKS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (win_clear),
      .hit    (hit_gated),
      .expire (win_expire)
   );

   pump_ratio_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .dev_on  (dev_on),
      .to_base (to_base),
      .expire  (win_expire),
      .ratio   (ratio_now),
      .valid   (ratio_ok)
   );

   assign ratio_code = ratio_now;

endmodule

// File: rtl/pump_ratio_seq_chk.sv
module pump_ratio_seq_chk #(
   parameter int FILT_TICKS = 160000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       dev_on,
   input logic       to_base,
   input logic       hit,
   input logic [1:0] code,
   input logic       ok
);

   // consecutive qualifying dropout edges in the current mode
   logic [31:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else if (!dev_on || code == 2'b00 || to_base || !hit) run_q <= '0;
      else if (run_q >= 32'(FILT_TICKS - 1)) run_q <= '0;
      else run_q <= run_q + 1;
   end

   p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_on && code != 2'b00 && !to_base && !hit) |=> $stable(code));

   p_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_on && code != 2'b00 && !to_base && run_q < 32'(FILT_TICKS - 1)) |=> $stable(code));

   p_order_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b01) |=> (code == 2'b01 || code == 2'b10 || code == 2'b00));

   p_order_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b10) |=> (code != 2'b11 || $past(!to_base)));

   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b11) |=> (code == 2'b11 || code == 2'b01 || code == 2'b00));

   p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_on && to_base && code != 2'b00) |=> (code == 2'b01));

   p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!dev_on) |=> (code == 2'b00 && !ok));

   p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_on && code == 2'b00) |=> (code == 2'b01));

   p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ok == (code != 2'b00));

endmodule

bind pump_ratio_seq pump_ratio_seq_chk #(.FILT_TICKS(FILT_TICKS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .dev_on  (dev_on),
   .to_base (to_base),
   .hit     (hit_gated),
   .code    (ratio_code),
   .ok      (ratio_ok)
);

// File: tb/pump_ratio_seq_test.sv
module pump_ratio_seq_test;

   localparam int NCH = 6;
   localparam int F   = 8;
   localparam int S   = 2;
   localparam int LAT = S + F;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           dev_on = 1'b0;
   logic [NCH-1:0] drop_flag = '0;
   logic [NCH-1:0] ch_mask = '0;
   logic           to_base = 1'b0;
   logic [1:0]     ratio_code;
   logic           ratio_ok;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   typedef struct { logic [1:0] code; int at; string tag; } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pump_ratio_seq #(.NUM_CH(NCH), .FILT_TICKS(F), .SYNC_STAGES(S)) uut (
      .clk(clk), .rst_n(rst_n), .dev_on(dev_on), .drop_flag(drop_flag),
      .ch_mask(ch_mask), .to_base(to_base),
      .ratio_code(ratio_code), .ratio_ok(ratio_ok)
   );

   task automatic check(input bit good, input string tag, input int act, input int exp);
      total++;
      if (!good) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic expect_at(input logic [1:0] code, input int at, input string tag);
      exp_t e;
      e.code = code; e.at = at; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic pulse_base;
      to_base = 1'b1;
      @(negedge clk);
      to_base = 1'b0;
   endtask

   // monitor: every change of the ratio must match the next queued item
   logic [1:0] prev_code = 2'b00;
   always @(negedge clk) begin
      if (rst_n && ratio_code !== prev_code) begin
         if (sb.size() == 0) begin
            check(1'b0, "unexpected ratio change", int'(ratio_code), int'(prev_code));
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(ratio_code === e.code, {e.tag, " code"}, int'(ratio_code), int'(e.code));
            check(cyc == e.at, {e.tag, " cycle"}, cyc, e.at);
            check(ratio_ok === (ratio_code != 2'b00), "R9 valid", int'(ratio_ok),
                  int'(ratio_code != 2'b00));
         end
         prev_code = ratio_code;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check(ratio_code === 2'b00, "R7 reset code", int'(ratio_code), 0);
      check(ratio_ok === 1'b0, "R7 reset valid", int'(ratio_ok), 0);
      rst_n = 1'b1;
      ch_mask = 6'b111110;
      @(negedge clk);

      // R1: wake into 1x
      dev_on = 1'b1;
      expect_at(2'b01, cyc + 1, "R1 wake");
      repeat (30) @(negedge clk);
      check(ratio_code === 2'b01, "R1 quiet stays 1x", int'(ratio_code), 1);

      // R2: dropout on a masked channel is ignored
      drop_flag = 6'b000001;
      repeat (30) @(negedge clk);
      check(ratio_code === 2'b01, "R2 masked channel", int'(ratio_code), 1);
      drop_flag = '0;
      repeat (5) @(negedge clk);

      // R3: a run one edge short of the window does nothing
      drop_flag = 6'b001000;
      repeat (F - 1) @(negedge clk);
      drop_flag = '0;
      repeat (20) @(negedge clk);
      check(ratio_code === 2'b01, "R3 short run", int'(ratio_code), 1);

      // R4/R5: persistent dropout climbs and wraps
      n = cyc;
      drop_flag = 6'b001000;
      expect_at(2'b10, n + LAT,         "R3 R4 first step");
      expect_at(2'b11, n + LAT + F,     "R4 second step");
      expect_at(2'b01, n + LAT + 2 * F, "R5 wrap");
      expect_at(2'b10, n + LAT + 3 * F, "R5 climb again");
      wait_to(n + LAT + 3 * F + 2);
      drop_flag = '0;
      repeat (20) @(negedge clk);
      check(ratio_code === 2'b10, "R5 hold after release", int'(ratio_code), 2);

      // R6: strobe returns to 1x
      n = cyc;
      expect_at(2'b01, n + 1, "R6 strobe");
      pulse_base();
      repeat (20) @(negedge clk);

      // R6 restart of window, then R8 collision with expiry
      n = cyc;
      drop_flag = 6'b100000;
      wait_to(n + 5);
      pulse_base();
      expect_at(2'b10, n + 14, "R6 window restarted");
      wait_to(n + 21);
      expect_at(2'b01, n + 22, "R8 strobe beats expiry");
      pulse_base();
      expect_at(2'b10, n + 30, "R8 full window after");
      wait_to(n + 31);
      drop_flag = '0;
      repeat (20) @(negedge clk);
      check(ratio_code === 2'b10, "R8 settled", int'(ratio_code), 2);

      // R7: shutdown, inputs ignored while off, restart at 1x
      n = cyc;
      dev_on = 1'b0;
      expect_at(2'b00, n + 1, "R7 off");
      @(negedge clk);
      check(ratio_ok === 1'b0, "R7 valid low", int'(ratio_ok), 0);
      drop_flag = 6'b000100;
      pulse_base();
      repeat (25) @(negedge clk);
      check(ratio_code === 2'b00, "R7 stays off", int'(ratio_code), 0);
      n = cyc;
      dev_on = 1'b1;
      expect_at(2'b01, n + 1, "R7 restart 1x");
      expect_at(2'b10, n + 1 + F, "R7 climb after restart");
      wait_to(n + 10);
      drop_flag = '0;
      repeat (20) @(negedge clk);
      check(ratio_code === 2'b10, "R7 final", int'(ratio_code), 2);
      check(sb.size() == 0, "all expected changes seen", sb.size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule